// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the processor-side register file of a four-channel DMA controller. A processor reaches it through sixteen byte-wide ports selected by a 4-bit address, with single-cycle read and write strobes. Per channel it keeps a 16-bit start address and a 16-bit transfer count, each held twice: a reload copy and a working copy. It also keeps a 6-bit mode field per channel, four channel mask bits, a command byte, four terminal-count flags and a byte holding the last transferred datum.

All of these values are driven out continuously to the transfer engine and the arbiter. The engine writes back the advancing working address and count and the terminal-count events. Sixteen-bit values move through the byte port as two accesses, low byte then high byte, steered by one byte-pointer flip-flop that all eight channel ports share. Separate command ports reset that pointer or clear the whole block.

Top module: `dma_regfile`

## Requirements
- R1: Port 2n holds channel n's address and port 2n+1 holds its count (n = 0..3). A read of either port returns the working copy, one byte per access: the low byte when the pointer is clear, the high byte when it is set.
- R2: A single byte-pointer flip-flop serves all eight channel ports. It flips after every read or write strobe to ports 0 to 7, whichever channel is addressed. The low-byte state follows reset.
- R3: A write to a channel port puts the byte into the same half of both the reload copy and the working copy of that register.
- R4: A write of any value to port 0xC returns the byte pointer to the low-byte state.
- R5: A write of any value to port 0xD is a master clear. It sets all four mask bits to 1 and clears every other register, the pointer and the flags included.
- R6: A pulse on `xfer_we` stores `xfer_data` in the temporary byte. A read of port 0xD returns that byte.
- R7: A write to port 0xA sets the mask bit of the channel in wdata[1:0] to wdata[2] and leaves the other mask bits unchanged. A write to port 0xF loads all four mask bits from wdata[3:0] (bit n is channel n).
- R8: A write to port 0xB stores wdata[7:2] as the mode of the channel in wdata[1:0]. The mode appears on `mode[6n+5:6n]`.
- R9: A read of port 0x8 returns {dreq_pend[3:0], tc[3:0]} and clears the terminal-count flags. A `tc_set` bit raises its flag. A flag set in the same cycle as the read survives it.
- R10: A write to port 0x8 loads the command byte.
- R11: Writes to ports 0x9 and 0xE change no register and leave the pointer alone. Reads of ports 0x9, 0xA, 0xB, 0xC, 0xE and 0xF return 0. `rdata` is 0 whenever `rd` is low.
- R12: When `upd_en[n]` is high, `upd_addr` and `upd_len` for channel n load the working copies and the reload copies stay unchanged. A processor write to the same register in that cycle takes precedence over the update for that register.
- R13: After synchronous reset the state matches a master clear: masks all 1 and everything else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Port address |
| wdata | input | 8 | Write data |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| rdata | output | 8 | Read data, valid while rd is high |
| upd_en | input | 4 | Per-channel working-value update enable |
| upd_addr | input | 64 | New working addresses, channel n at [16n+15:16n] |
| upd_len | input | 64 | New working counts, channel n at [16n+15:16n] |
| tc_set | input | 4 | Terminal-count events |
| dreq_pend | input | 4 | Pending requests reported in status |
| xfer_we | input | 1 | Load the temporary byte |
| xfer_data | input | 8 | Byte just transferred |
| base_addr | output | 64 | Reload addresses |
| cur_addr | output | 64 | Working addresses |
| base_len | output | 64 | Reload counts |
| cur_len | output | 64 | Working counts |
| mode | output | 24 | Mode fields, 6 bits per channel |
| mask | output | 4 | Channel mask bits |
| command | output | 8 | Command byte |

## Verification
The assertions check a fixed set of rules on every cycle. The pointer must flip on each channel-port access and return low after a pointer clear. Master clear must leave the masks set and the command, flags and pointer cleared. The two mask ports, the command write, flag set and status-read clearing, and the no-effect writes to port 0xE are checked the same way. Other behaviour shows only in the bench's scenarios: the low/high byte order across different channel ports, the reload copy staying put while the engine moves the working copy, a processor write winning over a same-cycle update, and the read-back values of every port class after each sequence.

// File: rtl/dma_regs_pkg.sv
// Shared constants and the decoded-strobe type of the DMA register interface.
// Assumes a 4-bit port address; ports 0..7 are the per-channel byte ports.
package dma_regs_pkg;

    localparam logic [3:0] PORT_STAT_CMD  = 4'h8;
    localparam logic [3:0] PORT_REQ_NOP   = 4'h9;
    localparam logic [3:0] PORT_MASK_ONE  = 4'hA;
    localparam logic [3:0] PORT_MODE      = 4'hB;
    localparam logic [3:0] PORT_PTR_CLR   = 4'hC;
    localparam logic [3:0] PORT_MCLR_TMP  = 4'hD;
    localparam logic [3:0] PORT_RSVD_NOP  = 4'hE;
    localparam logic [3:0] PORT_MASK_ALL  = 4'hF;

    typedef struct packed {
        logic       ch_wr;        // write to ports 0..7
        logic       ch_rd;        // read of ports 0..7
        logic [1:0] ch_sel;       // channel of a channel-port access
        logic       is_len;       // count (1) or address (0) register
        logic       stat_rd;      // status read
        logic       cmd_wr;       // command write
        logic       mask_one_wr;  // single mask write
        logic       mode_wr;      // mode write
        logic       ptr_clr;      // byte-pointer clear
        logic       mclr;         // master clear
        logic       temp_rd;      // temporary byte read
        logic       mask_all_wr;  // all-mask write
    } port_strb_t;

endpackage

// File: rtl/dma_port_decode.sv
// Port decoder: turns the address and the strobes into one-hot actions.
// Assumes rd and wr are never high together.
module dma_port_decode
    import dma_regs_pkg::*;
(
    input  logic [3:0]  addr,
    input  logic        rd,
    input  logic        wr,
    output port_strb_t  strb
);

    // Decode every port action from the address.
    always_comb begin
        strb             = '0;
        strb.ch_wr       = wr && !addr[3];
        strb.ch_rd       = rd && !addr[3];
        strb.ch_sel      = addr[2:1];
        strb.is_len      = addr[0];
        strb.stat_rd     = rd && (addr == PORT_STAT_CMD);
        strb.cmd_wr      = wr && (addr == PORT_STAT_CMD);
        strb.mask_one_wr = wr && (addr == PORT_MASK_ONE);
        strb.mode_wr     = wr && (addr == PORT_MODE);
        strb.ptr_clr     = wr && (addr == PORT_PTR_CLR);
        strb.mclr        = wr && (addr == PORT_MCLR_TMP);
        strb.temp_rd     = rd && (addr == PORT_MCLR_TMP);
        strb.mask_all_wr = wr && (addr == PORT_MASK_ALL);
    end

endmodule

// File: rtl/dma_byte_ptr.sv
// Shared low/high byte pointer for the channel ports.
// Assumes one step strobe per access; clear takes priority over step.
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic byte_hi
);

    // Flip on each channel access, return low on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            byte_hi <= 1'b0;
        end else if (step) begin
            byte_hi <= !byte_hi;
        end
    end

endmodule

// File: rtl/dma_reload_reg.sv
// One 16-bit channel value kept as a reload copy and a working copy.
// A processor byte write loads both copies; an engine update loads only
// the working copy and loses to a processor write in the same cycle.
// Assumes VW is exactly two bytes of DW.
module dma_reload_reg #(
    parameter int DW = 8,
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    input  logic          upd_en,
    input  logic [VW-1:0] upd_val,
    output logic [VW-1:0] base,
    output logic [VW-1:0] cur
);

    // Reload copy: written only by the processor.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            base <= '0;
        end else if (wr_lo) begin
            base[DW-1:0] <= wdata;
        end else if (wr_hi) begin
            base[VW-1:DW] <= wdata;
        end
    end

    // Working copy: processor byte write first, else engine update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cur <= '0;
        end else if (wr_lo) begin
            cur[DW-1:0] <= wdata;
        end else if (wr_hi) begin
            cur[VW-1:DW] <= wdata;
        end else if (upd_en) begin
            cur <= upd_val;
        end
    end

endmodule

// File: rtl/dma_ctrl_regs.sv
// Mask, mode, command, terminal-count and temporary-byte registers.
// Assumes NCH is 4 so that wdata[1:0] names a channel.
module dma_ctrl_regs #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int MW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclr,
    input  logic              mask_one_wr,
    input  logic              mask_all_wr,
    input  logic              mode_wr,
    input  logic              cmd_wr,
    input  logic              stat_rd,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH-1:0]    tc_set,
    input  logic              xfer_we,
    input  logic [DW-1:0]     xfer_data,
    output logic [NCH-1:0]    mask,
    output logic [NCH*MW-1:0] mode,
    output logic [DW-1:0]     command,
    output logic [NCH-1:0]    tc_q,
    output logic [DW-1:0]     temp
);

    logic [MW-1:0] mode_q [NCH];
    logic [1:0]    sel;

    assign sel = wdata[1:0];

    // Mask bits: set on clear, single-bit or all-bit update.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            mask <= '1;
        end else if (mask_one_wr) begin
            mask[sel] <= wdata[2];
        end else if (mask_all_wr) begin
            mask <= wdata[NCH-1:0];
        end
    end

    // Mode fields: upper bits of the byte to the selected channel.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            for (int i = 0; i < NCH; i++) begin
                mode_q[i] <= '0;
            end
        end else if (mode_wr) begin
            mode_q[sel] <= wdata[DW-1:DW-MW];
        end
    end

    // Command byte.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            command <= '0;
        end else if (cmd_wr) begin
            command <= wdata;
        end
    end

    // Terminal-count flags: cleared by a status read, new events kept.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            tc_q <= '0;
        end else begin
            tc_q <= (stat_rd ? '0 : tc_q) | tc_set;
        end
    end

    // Temporary byte: last datum reported by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            temp <= '0;
        end else if (xfer_we) begin
            temp <= xfer_data;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_mode_out
        assign mode[g*MW +: MW] = mode_q[g];
    end

endmodule

// File: rtl/dma_regfile.sv
// Processor-side register file of a four-channel DMA controller.
// Decodes the byte ports, keeps the per-channel reload/working values and
// control registers, and returns read data combinationally while rd is high.
// Assumes single-cycle rd/wr strobes that never overlap, and NCH = 4.
module dma_regfile
    import dma_regs_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int VW  = 16,
    parameter int MW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        addr,
    input  logic [DW-1:0]     wdata,
    input  logic              rd,
    input  logic              wr,
    output logic [DW-1:0]     rdata,
    input  logic [NCH-1:0]    upd_en,
    input  logic [NCH*VW-1:0] upd_addr,
    input  logic [NCH*VW-1:0] upd_len,
    input  logic [NCH-1:0]    tc_set,
    input  logic [NCH-1:0]    dreq_pend,
    input  logic              xfer_we,
    input  logic [DW-1:0]     xfer_data,
    output logic [NCH*VW-1:0] base_addr,
    output logic [NCH*VW-1:0] cur_addr,
    output logic [NCH*VW-1:0] base_len,
    output logic [NCH*VW-1:0] cur_len,
    output logic [NCH*MW-1:0] mode,
    output logic [NCH-1:0]    mask,
    output logic [DW-1:0]     command
);

    port_strb_t     strb;
    logic           byte_hi;
    logic [NCH-1:0] tc_q;
    logic [DW-1:0]  temp;
    logic [VW-1:0]  cur_a [NCH];
    logic [VW-1:0]  cur_l [NCH];
    logic [VW-1:0]  rd_word;
    logic [DW-1:0]  rd_byte;

    dma_port_decode u_dec (
        .addr (addr),
        .rd   (rd),
        .wr   (wr),
        .strb (strb)
    );

    dma_byte_ptr u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (strb.ptr_clr || strb.mclr),
        .step    (strb.ch_wr || strb.ch_rd),
        .byte_hi (byte_hi)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hit_a;
        logic hit_l;

        assign hit_a = strb.ch_wr && (strb.ch_sel == 2'(g)) && !strb.is_len;
        assign hit_l = strb.ch_wr && (strb.ch_sel == 2'(g)) &&  strb.is_len;

        dma_reload_reg #(.DW(DW), .VW(VW)) u_addr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (strb.mclr),
            .wr_lo   (hit_a && !byte_hi),
            .wr_hi   (hit_a &&  byte_hi),
            .wdata   (wdata),
            .upd_en  (upd_en[g]),
            .upd_val (upd_addr[g*VW +: VW]),
            .base    (base_addr[g*VW +: VW]),
            .cur     (cur_addr[g*VW +: VW])
        );

        dma_reload_reg #(.DW(DW), .VW(VW)) u_len (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (strb.mclr),
            .wr_lo   (hit_l && !byte_hi),
            .wr_hi   (hit_l &&  byte_hi),
            .wdata   (wdata),
            .upd_en  (upd_en[g]),
            .upd_val (upd_len[g*VW +: VW]),
            .base    (base_len[g*VW +: VW]),
            .cur     (cur_len[g*VW +: VW])
        );

        assign cur_a[g] = cur_addr[g*VW +: VW];
        assign cur_l[g] = cur_len[g*VW +: VW];
    end

    dma_ctrl_regs #(.NCH(NCH), .DW(DW), .MW(MW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mclr        (strb.mclr),
        .mask_one_wr (strb.mask_one_wr),
        .mask_all_wr (strb.mask_all_wr),
        .mode_wr     (strb.mode_wr),
        .cmd_wr      (strb.cmd_wr),
        .stat_rd     (strb.stat_rd),
        .wdata       (wdata),
        .tc_set      (tc_set),
        .xfer_we     (xfer_we),
        .xfer_data   (xfer_data),
        .mask        (mask),
        .mode        (mode),
        .command     (command),
        .tc_q        (tc_q),
        .temp        (temp)
    );

    // Pick the working word and the byte the pointer names.
    always_comb begin
        rd_word = strb.is_len ? cur_l[strb.ch_sel] : cur_a[strb.ch_sel];
        rd_byte = byte_hi ? rd_word[VW-1:DW] : rd_word[DW-1:0];
    end

    // Read mux: channel byte, status, temporary byte, else zero.
    always_comb begin
        rdata = '0;
        if (strb.ch_rd) begin
            rdata = rd_byte;
        end else if (strb.stat_rd) begin
            rdata = DW'({dreq_pend, tc_q});
        end else if (strb.temp_rd) begin
            rdata = temp;
        end
    end

endmodule

// File: rtl/dma_regfile_chk.sv
// Cycle rules of the DMA register interface, bound to dma_regfile.
// Observes ports plus the byte pointer and terminal-count flags.
module dma_regfile_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [3:0]     addr,
    input logic [DW-1:0]  wdata,
    input logic           rd,
    input logic           wr,
    input logic [NCH-1:0] mask,
    input logic [DW-1:0]  command,
    input logic [NCH-1:0] tc_set,
    input logic           byte_hi,
    input logic [NCH-1:0] tc_q
);

    p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr || rd) && !addr[3]) |=> (byte_hi != $past(byte_hi)));

    p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 4'hC) |=> !byte_hi);

    p_master_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 4'hD) |=> (mask == '1 && command == '0 && tc_q == '0 && !byte_hi));

    p_mask_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 4'hA) |=> (mask[$past(wdata[1:0])] == $past(wdata[2])));

    p_mask_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 4'hF) |=> (mask == $past(wdata[NCH-1:0])));

    p_tc_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tc_set) && !(wr && addr == 4'hD)) |=> ((tc_q & $past(tc_set)) == $past(tc_set)));

    p_tc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 4'h8) |=> ((tc_q & ~$past(tc_set)) == '0));

    p_cmd_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 4'h8) |=> (command == $past(wdata)));

    p_rsvd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == 4'hE || addr == 4'h9)) |=> ($stable(mask) && $stable(command) && $stable(byte_hi)));

endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .rd      (rd),
    .wr      (wr),
    .mask    (mask),
    .command (command),
    .tc_set  (tc_set),
    .byte_hi (byte_hi),
    .tc_q    (tc_q)
);

// File: tb/dma_regfile_tb.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module dma_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  rdata;
    logic [3:0]  upd_en = '0;
    logic [63:0] upd_addr = '0;
    logic [63:0] upd_len = '0;
    logic [3:0]  tc_set = '0;
    logic [3:0]  dreq_pend = '0;
    logic        xfer_we = 1'b0;
    logic [7:0]  xfer_data = '0;
    logic [63:0] base_addr, cur_addr, base_len, cur_len;
    logic [23:0] mode;
    logic [3:0]  mask;
    logic [7:0]  command;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = !clk;

    dma_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
        .rdata(rdata), .upd_en(upd_en), .upd_addr(upd_addr), .upd_len(upd_len),
        .tc_set(tc_set), .dreq_pend(dreq_pend), .xfer_we(xfer_we), .xfer_data(xfer_data),
        .base_addr(base_addr), .cur_addr(cur_addr), .base_len(base_len), .cur_len(cur_len),
        .mode(mode), .mask(mask), .command(command)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic cpu_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        addr = a; rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    // Monitor: compare each read byte against the queued expectation.
    always @(negedge clk) begin
        if (rd) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: actual=%0h expected=none", rdata);
            end else begin
                chk(tag_q.pop_front(), {56'd0, rdata}, {56'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R13 mask", {60'd0, mask}, 64'hF);
        chk("R13 cur_addr", cur_addr, 64'd0);
        chk("R13 command", {56'd0, command}, 64'd0);
        chk("R13 mode", {40'd0, mode}, 64'd0);
        chk("R11 idle rdata", {56'd0, rdata}, 64'd0);

        // R3/R1: channel 1 address, low then high byte.
        cpu_wr(4'h2, 8'h34);
        cpu_wr(4'h2, 8'h12);
        chk("R3 base_addr1", {48'd0, base_addr[31:16]}, 64'h1234);
        chk("R3 cur_addr1", {48'd0, cur_addr[31:16]}, 64'h1234);
        cpu_rd(4'h2, 8'h34, "R1 ch1 addr lo");
        cpu_rd(4'h2, 8'h12, "R1 ch1 addr hi");
        cpu_wr(4'h5, 8'hCD);
        cpu_wr(4'h5, 8'hAB);
        chk("R1 base_len2", {48'd0, base_len[47:32]}, 64'hABCD);
        chk("R3 cur_len2", {48'd0, cur_len[47:32]}, 64'hABCD);

        // R2: one pointer shared by all channel ports.
        cpu_wr(4'h0, 8'h11);
        cpu_wr(4'h7, 8'h22);
        chk("R2 shared ptr len3", {48'd0, cur_len[63:48]}, 64'h2200);
        cpu_rd(4'h0, 8'h11, "R2 read after cross-channel");

        // R4: pointer clear.
        cpu_wr(4'hC, 8'h00);
        cpu_wr(4'h0, 8'h55);
        cpu_wr(4'hC, 8'hFF);
        cpu_wr(4'h0, 8'h66);
        chk("R4 ptr clear", {48'd0, cur_addr[15:0]}, 64'h0066);
        cpu_wr(4'hC, 8'h00);

        // R12: engine update of working copies only.
        @(posedge clk); #1;
        upd_en = 4'b0010; upd_addr[31:16] = 16'hBEEF; upd_len[31:16] = 16'h0042;
        @(posedge clk); #1;
        upd_en = '0;
        chk("R12 cur_addr1", {48'd0, cur_addr[31:16]}, 64'hBEEF);
        chk("R12 base_addr1 kept", {48'd0, base_addr[31:16]}, 64'h1234);
        chk("R12 cur_len1", {48'd0, cur_len[31:16]}, 64'h0042);
        cpu_rd(4'h2, 8'hEF, "R12 read lo");
        cpu_rd(4'h2, 8'hBE, "R12 read hi");
        // R12: processor write wins over a same-cycle update.
        @(posedge clk); #1;
        upd_en = 4'b0001; upd_addr[15:0] = 16'hAAAA; upd_len[15:0] = 16'h0BAD;
        addr = 4'h0; wdata = 8'h77; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0; upd_en = '0;
        chk("R12 cpu wins", {48'd0, cur_addr[15:0]}, 64'h0077);
        chk("R12 other reg updated", {48'd0, cur_len[15:0]}, 64'h0BAD);
        cpu_wr(4'hC, 8'h00);

        // R9: status read and flag clearing.
        dreq_pend = 4'b1000;
        @(posedge clk); #1; tc_set = 4'b0101;
        @(posedge clk); #1; tc_set = '0;
        cpu_rd(4'h8, 8'h85, "R9 status");
        cpu_rd(4'h8, 8'h80, "R9 cleared");
        @(posedge clk); #1;
        addr = 4'h8; rd = 1'b1; tc_set = 4'b0010;
        exp_q.push_back(8'h80); tag_q.push_back("R9 read with set");
        @(posedge clk); #1;
        rd = 1'b0; tc_set = '0;
        cpu_rd(4'h8, 8'h82, "R9 set survives read");

        // R6: temporary byte.
        @(posedge clk); #1; xfer_we = 1'b1; xfer_data = 8'h5A;
        @(posedge clk); #1; xfer_we = 1'b0;
        cpu_rd(4'hD, 8'h5A, "R6 temp");

        // R7: mask ports.
        cpu_wr(4'hF, 8'h00);
        chk("R7 all clear", {60'd0, mask}, 64'h0);
        cpu_wr(4'hA, 8'h06);
        chk("R7 set ch2", {60'd0, mask}, 64'h4);
        cpu_wr(4'hA, 8'h07);
        chk("R7 set ch3", {60'd0, mask}, 64'hC);
        cpu_wr(4'hA, 8'h02);
        chk("R7 clear ch2", {60'd0, mask}, 64'h8);
        cpu_wr(4'hF, 8'h35);
        chk("R7 all load", {60'd0, mask}, 64'h5);

        // R8: mode port.
        cpu_wr(4'hB, 8'hD6);
        chk("R8 mode ch2", {58'd0, mode[17:12]}, 64'h35);
        cpu_wr(4'hB, 8'h03);
        chk("R8 mode all", {40'd0, mode}, 64'h035000);

        // R10: command byte.
        cpu_wr(4'h8, 8'hA5);
        chk("R10 command", {56'd0, command}, 64'hA5);

        // R11: ignored writes and zero reads.
        cpu_wr(4'hE, 8'hFF);
        cpu_wr(4'h9, 8'hFF);
        chk("R11 mask kept", {60'd0, mask}, 64'h5);
        chk("R11 command kept", {56'd0, command}, 64'hA5);
        chk("R11 mode kept", {40'd0, mode}, 64'h035000);
        cpu_wr(4'h4, 8'h99);
        chk("R11 ptr kept", {48'd0, cur_addr[47:32]}, 64'h0099);
        cpu_rd(4'h9, 8'h00, "R11 read 9");
        cpu_rd(4'hA, 8'h00, "R11 read A");
        cpu_rd(4'hB, 8'h00, "R11 read B");
        cpu_rd(4'hC, 8'h00, "R11 read C");
        cpu_rd(4'hE, 8'h00, "R11 read E");
        cpu_rd(4'hF, 8'h00, "R11 read F");

        // R5: master clear with pointer high.
        cpu_wr(4'hD, 8'h3C);
        chk("R5 mask", {60'd0, mask}, 64'hF);
        chk("R5 command", {56'd0, command}, 64'h0);
        chk("R5 mode", {40'd0, mode}, 64'h0);
        chk("R5 base_len", base_len, 64'h0);
        chk("R5 cur_addr", cur_addr, 64'h0);
        cpu_wr(4'h0, 8'h44);
        chk("R5 ptr low", {48'd0, cur_addr[15:0]}, 64'h0044);
        cpu_rd(4'hD, 8'h00, "R5 temp cleared");
        cpu_rd(4'h8, 8'h80, "R5 flags cleared");

        repeat (3) @(posedge clk);
        chk("scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule